// File: doc/BRIEF.md
# Dual-Bank General-Purpose Register File with Long Pairs

This block stores the working registers of a two-sided datapath. It has two independent banks, A and B. Each bank has sixteen 32-bit registers, numbered 0 to 15. A register can hold data, an address pointer or a condition value. Operands of 16 bits and 32 bits sit in one register.

A 40-bit "long" operand uses an aligned register pair. The even register holds the low 32 bits. The odd register directly above it holds the top 8 bits.

Every read port and every write port carries its own bank select, pair-mode flag and register address, so any port can reach either bank. With the default of four read ports and two write ports, a multiply lane and an add/logic lane can each fetch two operands and retire one result in the same cycle. Reads are combinational. Writes land on the rising clock edge.

The ports are plain register-file pins: there is no stream handshake. A read completes in the cycle its address is presented. A write is always accepted on the edge where its enable is high, so no back-pressure exists.

Top module: `dual_bank_regfile`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge clears all 32 registers of both banks to zero.
- R2: A single write (pair flag 0) stores `wr_data[31:0]` into the addressed register, and `wr_data[39:32]` is ignored. A single read returns `{8'h00, reg}`.
- R3: All read ports work independently in the same cycle. Each port may read a different bank, address and mode.
- R4: Reads are combinational. A write becomes visible only after the rising edge it is sampled on, and before that edge the old value is read.
- R5: Bank select 0 addresses bank A and bank select 1 addresses bank B. Register n of A and register n of B are distinct storage.
- R6: A pair write with index n updates register 2n with `wr_data[31:0]`. It also updates register 2n+1 with `{24'h0, wr_data[39:32]}`.
- R7: A pair read with index n returns `{reg(2n+1)[7:0], reg(2n)[31:0]}`. Bits [31:8] of the odd register never appear in the result.
- R8: In pair mode the pair index is `addr[2:0]` and `addr[3]` is ignored, so a misaligned pair cannot be formed.
- R9: If two write ports hit the same register in the same cycle, the higher-numbered port wins. This applies per register, so a pair write and a single write that overlap on one half each keep their own unclaimed half.
- R10: A write port whose enable is low changes no register.
- R11: Writes from different ports to different registers or banks in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_WR | Write enable per write port |
| wr_bank | input | NUM_WR | Bank select per write port (0 = A, 1 = B) |
| wr_pair | input | NUM_WR | 1 = 40-bit pair write, 0 = 32-bit single write |
| wr_addr | input | NUM_WR x 4 | Register index, or pair index in bits [2:0] |
| wr_data | input | NUM_WR x 40 | Write data; bits [39:32] used only in pair mode |
| rd_bank | input | NUM_RD | Bank select per read port (0 = A, 1 = B) |
| rd_pair | input | NUM_RD | 1 = 40-bit pair read, 0 = 32-bit single read |
| rd_addr | input | NUM_RD x 4 | Register index, or pair index in bits [2:0] |
| rd_data | output | NUM_RD x 40 | Read data, zero-extended in single mode |

## Verification
A vector table walks single writes, pair writes and disabled writes through one port. It reads back in both modes. Reading one register through single and pair views tells the even half apart from the odd half, and shows that odd-register bits [31:8] are dropped. Pair indices with bit 3 set and with bit 3 clear show that the index is taken from the low three bits. Same-cycle write pairs to one register, to overlapping halves and to separate banks show that collisions resolve per register toward the higher port. A read taken just before the write edge shows the combinational read timing.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int REG_W  = 32;
  localparam int EXT_W  = 8;
  localparam int LONG_W = REG_W + EXT_W;
  localparam int NREG   = 16;
  localparam int NBANK  = 2;
  localparam int AW     = $clog2(NREG);
  localparam int PW     = AW - 1;

  typedef logic [REG_W-1:0]  word_t;
  typedef logic [LONG_W-1:0] long_t;
  typedef logic [AW-1:0]     ridx_t;
  typedef logic [PW-1:0]     pidx_t;
endpackage

// File: rtl/rf_wr_steer.sv
module rf_wr_steer
  import rf_pkg::*;
#(
  parameter int NUM_WR  = 2,
  parameter int BANK_ID = 0
) (
  input  logic [NUM_WR-1:0]             en,
  input  logic [NUM_WR-1:0]             bank,
  input  logic [NUM_WR-1:0]             pair,
  input  logic [NUM_WR-1:0][AW-1:0]     addr,
  input  logic [NUM_WR-1:0][LONG_W-1:0] data,
  output logic [NREG-1:0]               reg_we,
  output logic [NREG-1:0][REG_W-1:0]    reg_wd
);
  localparam logic MY_BANK = 1'(BANK_ID);

  // Ports are visited low to high, so a later port overrides an earlier one register by register.
  always_comb begin
    ridx_t ev_idx;
    ridx_t od_idx;
    reg_we = '0;
    reg_wd = '0;
    ev_idx = '0;
    od_idx = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (en[p] && (bank[p] == MY_BANK)) begin
        if (pair[p]) begin
          ev_idx = {addr[p][PW-1:0], 1'b0};
          od_idx = {addr[p][PW-1:0], 1'b1};
          reg_we[ev_idx] = 1'b1;
          reg_wd[ev_idx] = data[p][REG_W-1:0];
          reg_we[od_idx] = 1'b1;
          reg_wd[od_idx] = {{(REG_W-EXT_W){1'b0}}, data[p][LONG_W-1:REG_W]};
        end else begin
          reg_we[addr[p]] = 1'b1;
          reg_wd[addr[p]] = data[p][REG_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREG-1:0]            reg_we,
  input  logic [NREG-1:0][REG_W-1:0] reg_wd,
  output logic [NREG-1:0][REG_W-1:0] reg_q
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            reg_q[r] <= '0;
      else if (reg_we[r]) reg_q[r] <= reg_wd[r];
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
(
  input  logic [NBANK-1:0][NREG-1:0][REG_W-1:0] all_q,
  input  logic                                  bank,
  input  logic                                  pair,
  input  logic [AW-1:0]                         addr,
  output logic [LONG_W-1:0]                     data
);
  word_t sel_ev, sel_od, sel_one;

  always_comb begin
    sel_ev  = all_q[bank][{addr[PW-1:0], 1'b0}];
    sel_od  = all_q[bank][{addr[PW-1:0], 1'b1}];
    sel_one = all_q[bank][addr];
    if (pair) data = {sel_od[EXT_W-1:0], sel_ev};
    else      data = {{EXT_W{1'b0}}, sel_one};
  end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import rf_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int NUM_WR = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_WR-1:0]                wr_en,
  input  logic [NUM_WR-1:0]                wr_bank,
  input  logic [NUM_WR-1:0]                wr_pair,
  input  logic [NUM_WR-1:0][3:0]           wr_addr,
  input  logic [NUM_WR-1:0][39:0]          wr_data,
  input  logic [NUM_RD-1:0]                rd_bank,
  input  logic [NUM_RD-1:0]                rd_pair,
  input  logic [NUM_RD-1:0][3:0]           rd_addr,
  output logic [NUM_RD-1:0][39:0]          rd_data
);
  logic [NBANK-1:0][NREG-1:0][REG_W-1:0] bank_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [NREG-1:0]            we;
    logic [NREG-1:0][REG_W-1:0] wd;

    rf_wr_steer #(.NUM_WR(NUM_WR), .BANK_ID(b)) u_steer (
      .en(wr_en), .bank(wr_bank), .pair(wr_pair),
      .addr(wr_addr), .data(wr_data),
      .reg_we(we), .reg_wd(wd)
    );

    rf_bank u_store (
      .clk(clk), .rst(rst), .reg_we(we), .reg_wd(wd), .reg_q(bank_q[b])
    );
  end

  for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
    rf_rd_port u_rd (
      .all_q(bank_q), .bank(rd_bank[i]), .pair(rd_pair[i]),
      .addr(rd_addr[i]), .data(rd_data[i])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_RD = 4,
  parameter int NUM_WR = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_WR-1:0]       wr_en,
  input logic [NUM_WR-1:0]       wr_bank,
  input logic [NUM_WR-1:0]       wr_pair,
  input logic [NUM_WR-1:0][3:0]  wr_addr,
  input logic [NUM_WR-1:0][39:0] wr_data,
  input logic [NUM_RD-1:0]       rd_bank,
  input logic [NUM_RD-1:0]       rd_pair,
  input logic [NUM_RD-1:0][3:0]  rd_addr,
  input logic [NUM_RD-1:0][39:0] rd_data
);
  localparam int HI = NUM_WR - 1;

  for (genvar i = 0; i < NUM_RD; i++) begin : g_port
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> rd_data[i] == 40'h0) else $error("reset clear"); // R1

    AST_SINGLE_ZEXT: assert property (@(posedge clk) disable iff (rst)
      !rd_pair[i] |-> rd_data[i][39:32] == 8'h00) else $error("single zext"); // R2
  end

  AST_HI_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en[HI] && !wr_pair[HI] |=>
      (rd_pair[0] || rd_bank[0] != $past(wr_bank[HI]) || rd_addr[0] != $past(wr_addr[HI])
       || rd_data[0] == {8'h00, $past(wr_data[HI][31:0])})) else $error("port priority"); // R9

  AST_PAIR_ROUNDTRIP: assert property (@(posedge clk) disable iff (rst)
    wr_en[HI] && wr_pair[HI] |=>
      (!rd_pair[0] || rd_bank[0] != $past(wr_bank[HI]) || rd_addr[0][2:0] != $past(wr_addr[HI][2:0])
       || rd_data[0] == $past(wr_data[HI]))) else $error("pair roundtrip"); // R6

  AST_BANK_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    ((wr_en & wr_bank) == '0) && rd_bank[0] |=>
      (!rd_bank[0] || !$stable(rd_addr[0]) || !$stable(rd_pair[0]) || $stable(rd_data[0])))
    else $error("bank isolation"); // R5

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en == '0 |=>
      (!$stable(rd_addr[0]) || !$stable(rd_pair[0]) || !$stable(rd_bank[0]) || $stable(rd_data[0])))
    else $error("idle write"); // R10
endmodule

bind dual_bank_regfile rf_checker #(.NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) u_rf_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_pair(wr_pair),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_bank(rd_bank), .rd_pair(rd_pair),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_dual_bank_regfile.sv
module tb_dual_bank_regfile;
  localparam int NR = 4;
  localparam int NW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]       wr_en = '0, wr_bank = '0, wr_pair = '0;
  logic [NW-1:0][3:0]  wr_addr = '0;
  logic [NW-1:0][39:0] wr_data = '0;
  logic [NR-1:0]       rd_bank = '0, rd_pair = '0;
  logic [NR-1:0][3:0]  rd_addr = '0;
  logic [NR-1:0][39:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bank_regfile #(.NUM_RD(NR), .NUM_WR(NW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_pair(wr_pair),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_bank(rd_bank), .rd_pair(rd_pair),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {wen, wbank, wpair, waddr[4], wdata[40], rbank, rpair, raddr[4], expect[40]}
  localparam logic [92:0] VEC [0:8] = '{
    {1'b1,1'b0,1'b0,4'd3, 40'hAA11223344, 1'b0,1'b0,4'd3, 40'h0011223344}, // R2
    {1'b1,1'b1,1'b0,4'd3, 40'h0055667788, 1'b0,1'b0,4'd3, 40'h0011223344}, // R5
    {1'b1,1'b0,1'b1,4'd2, 40'hC3DEADBEEF, 1'b0,1'b1,4'd2, 40'hC3DEADBEEF}, // R6 R7
    {1'b1,1'b0,1'b0,4'd7, 40'h00FFFFFF12, 1'b0,1'b0,4'd5, 40'h00000000C3}, // R6
    {1'b1,1'b1,1'b1,4'hB, 40'h5A01020304, 1'b1,1'b1,4'd3, 40'h5A01020304}, // R8
    {1'b0,1'b0,1'b0,4'd3, 40'h0000000099, 1'b0,1'b0,4'd3, 40'h0011223344}, // R10
    {1'b1,1'b0,1'b0,4'd13,40'h00ABCDEF99, 1'b0,1'b1,4'd6, 40'h9900000000}, // R7
    {1'b1,1'b1,1'b0,4'd15,40'h0000000007, 1'b1,1'b1,4'hF, 40'h0700000000}, // R8
    {1'b0,1'b1,1'b0,4'd0, 40'h0000000000, 1'b0,1'b1,4'd3, 40'h1200000000}  // R7
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_wr(input int p, input bit en, input bit bk, input bit pr,
                        input logic [3:0] a, input logic [39:0] d);
    wr_en[p] = en; wr_bank[p] = bk; wr_pair[p] = pr; wr_addr[p] = a; wr_data[p] = d;
  endtask

  task automatic set_rd(input int p, input bit bk, input bit pr, input logic [3:0] a);
    rd_bank[p] = bk; rd_pair[p] = pr; rd_addr[p] = a;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = '0;
  endtask

  task automatic check_all_zero(input string req);
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 16; r++) begin
        set_rd(0, b[0], 1'b0, r[3:0]);
        #1;
        chk(req, rd_data[0], 40'h0);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_all_zero("R1 after reset");

    // Vector table through port 0
    for (int k = 0; k < 9; k++) begin
      logic [92:0] v;
      v = VEC[k];
      @(negedge clk);
      set_wr(0, v[92], v[91], v[90], v[89:86], v[85:46]);
      tick();
      set_rd(0, v[45], v[44], v[43:40]);
      #1;
      chk($sformatf("R2/R5-R8/R10 vector %0d", k), rd_data[0], v[39:0]);
    end

    // R3: four ports at once
    set_rd(0, 1'b0, 1'b0, 4'd3);
    set_rd(1, 1'b1, 1'b0, 4'd3);
    set_rd(2, 1'b0, 1'b1, 4'd2);
    set_rd(3, 1'b1, 1'b1, 4'd3);
    #1;
    chk("R3 port0", rd_data[0], 40'h0011223344);
    chk("R3 port1", rd_data[1], 40'h0055667788);
    chk("R3 port2", rd_data[2], 40'hC3DEADBEEF);
    chk("R3 port3", rd_data[3], 40'h5A01020304);

    // R4: old value before the edge, new value after
    @(negedge clk);
    set_wr(0, 1'b1, 1'b0, 1'b0, 4'd1, 40'h0000001234);
    set_rd(0, 1'b0, 1'b0, 4'd1);
    #1;
    chk("R4 before edge", rd_data[0], 40'h0);
    tick();
    chk("R4 after edge", rd_data[0], 40'h0000001234);

    // R9: same register, port 1 wins
    @(negedge clk);
    set_wr(0, 1'b1, 1'b0, 1'b0, 4'd9, 40'h0000000111);
    set_wr(1, 1'b1, 1'b0, 1'b0, 4'd9, 40'h0000000222);
    tick();
    set_rd(0, 1'b0, 1'b0, 4'd9);
    #1;
    chk("R9 same reg", rd_data[0], 40'h0000000222);

    // R9: pair on port 0, single odd on port 1
    @(negedge clk);
    set_wr(0, 1'b1, 1'b0, 1'b1, 4'd4, 40'h77AAAA0000);
    set_wr(1, 1'b1, 1'b0, 1'b0, 4'd9, 40'h0000000333);
    tick();
    set_rd(0, 1'b0, 1'b0, 4'd8);
    set_rd(1, 1'b0, 1'b0, 4'd9);
    #1;
    chk("R9 pair even kept", rd_data[0], 40'h00AAAA0000);
    chk("R9 odd by port1", rd_data[1], 40'h0000000333);

    // R9: single even on port 0, pair on port 1
    @(negedge clk);
    set_wr(0, 1'b1, 1'b0, 1'b0, 4'd8, 40'h0000000444);
    set_wr(1, 1'b1, 1'b0, 1'b1, 4'd4, 40'h66BBBB0000);
    tick();
    set_rd(0, 1'b0, 1'b1, 4'd4);
    #1;
    chk("R9 pair on port1 wins", rd_data[0], 40'h66BBBB0000);

    // R11: both ports, different banks
    @(negedge clk);
    set_wr(0, 1'b1, 1'b0, 1'b0, 4'd10, 40'h000000000A);
    set_wr(1, 1'b1, 1'b1, 1'b0, 4'd10, 40'h000000000B);
    tick();
    set_rd(0, 1'b0, 1'b0, 4'd10);
    set_rd(1, 1'b1, 1'b0, 4'd10);
    #1;
    chk("R11 bank A", rd_data[0], 40'h000000000A);
    chk("R11 bank B", rd_data[1], 40'h000000000B);

    // R1: reset again clears written contents
    @(negedge clk);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check_all_zero("R1 mid-run reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule